// File: doc/BRIEF.md
# Toggle-on-Write FIFO Interrupt Controller

This block collects four FIFO level conditions into a single interrupt line for a host processor. Each condition latches into its own status bit the cycle it is seen. The host reads status, per-source enable and global enable through a small register bus, with one write strobe and a combinational read path. A status bit is changed by writing a 1 to its position, which inverts it. This lets software acknowledge an event or force it for test with the same access. The interrupt line is the global enable ANDed with the OR of the enabled status bits, and it is registered.

The output is produced by a two-state machine. In `IRQ_QUIET` the line is low. The transition `RAISE` moves it to `IRQ_RAISED` when a pending, enabled source exists under global enable. In `IRQ_RAISED` the line is high, and the transition `DROP` returns it to `IRQ_QUIET` once nothing enabled is pending or the global enable is cleared. Both states otherwise hold.

Top module: `tw_irq_ctrl`

## Requirements
- R1: An active-low reset clears every status bit, every source enable and the global enable, and drives `irq` low. Reads then return 0 at offsets 0x1C, 0x20 and 0x28.
- R2: Source bits sit at fixed positions in the status and enable registers: bit 0 is write FIFO below half, bit 1 is read FIFO above half, bit 2 is write FIFO empty, and bit 3 is read FIFO full. A condition seen high at a clock edge sets its status bit at that edge, and the bit stays set after the condition falls.
- R3: A write to offset 0x20 inverts each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. An inverted bit may go 0 to 1 as well as 1 to 0.
- R4: If a condition is high on the same edge as a write that would invert its bit, the bit ends up 1. While a condition stays high, its status bit stays 1.
- R5: Offset 0x28 holds one enable per source in bits 3:0. A 1 enables a source, a 0 disables it, and the register reads back what was written.
- R6: Offset 0x1C holds the global enable in bit 31. It is readable and writable, and every other bit of that offset reads 0.
- R7: `irq` equals the global enable AND the OR over sources of status AND enable, as those registers stood one clock earlier. A change to any of them appears on `irq` one cycle later.
- R8: Bits 31:4 of offsets 0x20 and 0x28 read 0 and ignore writes. Any other offset reads 0, and writing to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| fifo_cond | input | 4 | Level conditions, bit order as in R2 |
| irq | output | 1 | Registered interrupt line |

## Verification
A new condition and a host inverting write to the same status bit can land on one clock edge. This is the race R4 settles. The bench first leaves status bit 1 set. It then raises the read-above-half condition in the very cycle that a write of 0x2 to offset 0x20 is on the bus, and reads the status back, expecting bit 1 still at 1. It repeats the write while the condition is held, then drops the condition and writes once more. The bit must now clear, which shows that the earlier writes were really overridden and not lost.

// File: rtl/tw_irq_pkg.sv
package tw_irq_pkg;

    localparam int unsigned SRC_COUNT  = 4;
    localparam int unsigned WORD_BITS  = 32;
    localparam int unsigned OFFS_BITS  = 8;

    localparam logic [7:0] OFFS_GLOBAL = 8'h1C;
    localparam logic [7:0] OFFS_STATUS = 8'h20;
    localparam logic [7:0] OFFS_ENABLE = 8'h28;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_GLOBAL,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/tw_irq_decode.sv
module tw_irq_decode
    import tw_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = OFFS_BITS,
    parameter int unsigned DATA_W = WORD_BITS,
    parameter int unsigned N_SRC  = SRC_COUNT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [N_SRC-1:0]  status_q,
    input  logic [N_SRC-1:0]  enable_q,
    input  logic              gie_q,
    output logic              wr_global,
    output logic              wr_status,
    output logic              wr_enable,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned GIE_BIT = DATA_W - 1;

    reg_sel_e sel;

    always_comb begin
        if (addr == ADDR_W'(OFFS_GLOBAL)) begin
            sel = SEL_GLOBAL;
        end else if (addr == ADDR_W'(OFFS_STATUS)) begin
            sel = SEL_STATUS;
        end else if (addr == ADDR_W'(OFFS_ENABLE)) begin
            sel = SEL_ENABLE;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        wr_global = 1'b0;
        wr_status = 1'b0;
        wr_enable = 1'b0;
        rdata     = '0;
        unique case (sel)
            SEL_GLOBAL: begin
                wr_global      = wr;
                rdata[GIE_BIT] = gie_q;
            end
            SEL_STATUS: begin
                wr_status          = wr;
                rdata[N_SRC-1:0]   = status_q;
            end
            SEL_ENABLE: begin
                wr_enable          = wr;
                rdata[N_SRC-1:0]   = enable_q;
            end
            SEL_NONE: begin
                rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/tw_irq_status.sv
module tw_irq_status
    import tw_irq_pkg::*;
#(
    parameter int unsigned N_SRC = SRC_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] cond,
    input  logic             flip_en,
    input  logic [N_SRC-1:0] flip_mask,
    output logic [N_SRC-1:0] status_q
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        logic flipped;
        assign flipped = status_q[g] ^ (flip_en & flip_mask[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[g] <= 1'b0;
            end else begin
                status_q[g] <= cond[g] | flipped;
            end
        end
    end

endmodule

// File: rtl/tw_irq_line.sv
module tw_irq_line
    import tw_irq_pkg::*;
#(
    parameter int unsigned N_SRC = SRC_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] status_q,
    input  logic [N_SRC-1:0] enable_q,
    input  logic             gie_q,
    output logic             irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       pending;

    assign pending = gie_q & (|(status_q & enable_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_QUIET:  irq = 1'b0;
            IRQ_RAISED: irq = 1'b1;
        endcase
    end

endmodule

// File: rtl/tw_irq_ctrl.sv
module tw_irq_ctrl
    import tw_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = OFFS_BITS,
    parameter int unsigned DATA_W = WORD_BITS,
    parameter int unsigned N_SRC  = SRC_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  fifo_cond,
    output logic              irq
);

    localparam int unsigned GIE_BIT = DATA_W - 1;

    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] enable_q;
    logic             gie_q;
    logic             wr_global;
    logic             wr_status;
    logic             wr_enable;

    tw_irq_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_SRC  (N_SRC)
    ) u_decode (
        .addr      (reg_addr),
        .wr        (reg_wr),
        .status_q  (status_q),
        .enable_q  (enable_q),
        .gie_q     (gie_q),
        .wr_global (wr_global),
        .wr_status (wr_status),
        .wr_enable (wr_enable),
        .rdata     (reg_rdata)
    );

    tw_irq_status #(
        .N_SRC (N_SRC)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (fifo_cond),
        .flip_en   (wr_status),
        .flip_mask (reg_wdata[N_SRC-1:0]),
        .status_q  (status_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            gie_q    <= 1'b0;
        end else begin
            if (wr_enable) enable_q <= reg_wdata[N_SRC-1:0];
            if (wr_global) gie_q    <= reg_wdata[GIE_BIT];
        end
    end

    tw_irq_line #(
        .N_SRC (N_SRC)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_q (status_q),
        .enable_q (enable_q),
        .gie_q    (gie_q),
        .irq      (irq)
    );

endmodule

// File: rtl/tw_irq_ctrl_chk.sv
module tw_irq_ctrl_chk
    import tw_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = OFFS_BITS,
    parameter int unsigned DATA_W = WORD_BITS,
    parameter int unsigned N_SRC  = SRC_COUNT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [N_SRC-1:0]  fifo_cond,
    input logic              irq,
    input logic [N_SRC-1:0]  status_q,
    input logic [N_SRC-1:0]  enable_q,
    input logic              gie_q
);

    logic hits_status;
    logic hits_enable;
    logic hits_global;

    assign hits_status = (reg_addr == ADDR_W'(OFFS_STATUS));
    assign hits_enable = (reg_addr == ADDR_W'(OFFS_ENABLE));
    assign hits_global = (reg_addr == ADDR_W'(OFFS_GLOBAL));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!irq)
                else $error("irq high during reset");
        end
    end

    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(gie_q & (|(status_q & enable_q))))
        else $error("irq does not follow registered pending");

    assert_cond_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cond != '0) |=> ((status_q & $past(fifo_cond)) == $past(fifo_cond)))
        else $error("condition did not set its status bit");

    assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && hits_status) && fifo_cond == '0) |=> $stable(status_q))
        else $error("status changed without write or condition");

    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hits_enable) |=> $stable(enable_q))
        else $error("enable changed without write");

    assert_gie_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hits_global) |=> $stable(gie_q))
        else $error("global enable changed without write");

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hits_status || hits_enable) |-> (reg_rdata[DATA_W-1:N_SRC] == '0))
        else $error("undefined bits read nonzero");

endmodule

bind tw_irq_ctrl tw_irq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_SRC  (N_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .fifo_cond (fifo_cond),
    .irq       (irq),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .gie_q     (gie_q)
);

// File: tb/tb_tw_irq_ctrl.sv
module tb_tw_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_GLB = 8'h1C;
    localparam logic [7:0] A_STS = 8'h20;
    localparam logic [7:0] A_ENA = 8'h28;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  fifo_cond = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fifo_cond (fifo_cond),
        .irq       (irq)
    );

    // Monitor: compares one queued expectation per falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
            end
        end
    end

    // Driver tasks: always entered just after a rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] c);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        fifo_cond = c;
        tick();
        reg_wr    = 1'b0;
        reg_wdata = '0;
        fifo_cond = '0;
    endtask

    task automatic pulse_cond(input logic [3:0] c);
        fifo_cond = c;
        tick();
        fifo_cond = '0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        sb_item_t it;
        reg_addr = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.req    = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        tick();
    endtask

    task automatic expect_irq_now(input logic e, input string req);
        sb_item_t it;
        it.is_irq = 1'b1;
        it.exp    = {31'b0, e};
        it.req    = req;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        expect_irq_now(1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        tick();
        expect_rd(A_STS, 32'h0, "R1 status after reset");
        expect_rd(A_ENA, 32'h0, "R1 enable after reset");
        expect_rd(A_GLB, 32'h0, "R1 global after reset");

        // R2 latch and bit positions
        pulse_cond(4'b0001);
        expect_rd(A_STS, 32'h1, "R2 write-below-half latched bit0");
        pulse_cond(4'b1000);
        expect_rd(A_STS, 32'h9, "R2 read-full latched bit3");

        // R3 toggle on write
        bus_write(A_STS, 32'h1, 4'b0);
        expect_rd(A_STS, 32'h8, "R3 write 1 inverts bit0 to 0");
        bus_write(A_STS, 32'h0, 4'b0);
        expect_rd(A_STS, 32'h8, "R3 write 0 leaves status");
        bus_write(A_STS, 32'h6, 4'b0);
        expect_rd(A_STS, 32'hE, "R3 write 1 inverts bits1,2 to 1");

        // R8 upper bits ignored
        bus_write(A_STS, 32'hFFFF_FFF0, 4'b0);
        expect_rd(A_STS, 32'hE, "R8 status upper bits ignored");
        bus_write(A_ENA, 32'hFFFF_FFFF, 4'b0);
        expect_rd(A_ENA, 32'hF, "R8 enable upper bits read 0");

        // R5 enable register
        bus_write(A_ENA, 32'h5, 4'b0);
        expect_rd(A_ENA, 32'h5, "R5 enable readback");

        // R6 global enable; R7 registered output
        expect_irq_now(1'b0, "R7 no irq without global enable");
        tick();
        bus_write(A_GLB, 32'hFFFF_FFFF, 4'b0);
        expect_irq_now(1'b0, "R7 irq still low in write-following cycle");
        expect_rd(A_GLB, 32'h8000_0000, "R6 global only bit31");
        expect_irq_now(1'b1, "R7 irq high one cycle later");
        tick();
        bus_write(A_GLB, 32'h0, 4'b0);
        tick();
        expect_irq_now(1'b0, "R7 irq low after global cleared");
        tick();
        bus_write(A_GLB, 32'h8000_0000, 4'b0);
        tick();
        expect_irq_now(1'b1, "R7 irq back with global set");
        tick();
        bus_write(A_ENA, 32'h1, 4'b0);
        tick();
        expect_irq_now(1'b0, "R7 irq masked when enabled bit not pending");
        tick();

        // R4 set wins over toggle in same cycle
        bus_write(A_STS, 32'h2, 4'b0010);
        expect_rd(A_STS, 32'hE, "R4 set wins over toggle");
        fifo_cond = 4'b0010;
        reg_addr  = A_STS;
        reg_wdata = 32'h2;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
        expect_rd(A_STS, 32'hE, "R4 bit held while condition high");
        fifo_cond = 4'b0000;
        bus_write(A_STS, 32'h2, 4'b0);
        expect_rd(A_STS, 32'hC, "R3 toggle clears once condition gone");

        // R8 unmapped offset
        bus_write(8'h24, 32'hFFFF_FFFF, 4'b0);
        expect_rd(8'h24, 32'h0, "R8 unmapped offset reads 0");
        expect_rd(A_STS, 32'hC, "R8 unmapped write left status");
        expect_rd(A_ENA, 32'h1, "R8 unmapped write left enable");
        expect_rd(A_GLB, 32'h8000_0000, "R8 unmapped write left global");

        // R1 reset mid-run
        bus_write(A_ENA, 32'hF, 4'b0);
        tick();
        expect_irq_now(1'b1, "R7 irq with all sources enabled");
        rst_n = 1'b0;
        #1;
        expect_irq_now(1'b0, "R1 irq cleared by reset");
        rst_n = 1'b1;
        tick();
        expect_rd(A_STS, 32'h0, "R1 status cleared by reset");
        expect_rd(A_ENA, 32'h0, "R1 enable cleared by reset");
        expect_rd(A_GLB, 32'h0, "R1 global cleared by reset");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule